// File: doc/BRIEF.md
# Tag-Check Exception Controller

This block turns failed tag-check requests from the pipeline into precise exceptions that run at user level. A failing instruction is stopped before it commits. Fetch is sent to a handler address that software programs. A single trusted-mode bit is then set. That bit is independent of the user/kernel privilege level, which the block never touches.

While the bit is set, tag propagation and checking are switched off. The handler may then work with the policy configuration, the saved exception state and raw tags. The saved state is the faulting PC, the identifier of the failing operand and the mask of failing policies. A return request ends the handler: fetch resumes at a PC that software supplies, and checking is enabled again.

Out of reset the block is in trusted mode, so boot code can program the handler address before any check runs.

Top module: `tagexc_unit`

## Requirements
- R1: While reset is asserted, and until the first update after it, trustedMode = 1 and tagCheckEn = 0. savedPc, savedOperand and savedMask are 0, and handlerAddr equals the HANDLER_RST parameter (0 by default).
- R2: A cycle with chkFail = 1, commitValid = 1 and trustedMode = 0 is an exception. In that same cycle commitSuppress = 1, redirectValid = 1 and redirectPc = handlerAddr.
- R3: On the clock edge that ends an exception cycle, savedPc, savedOperand and savedMask take that cycle's curPc, failOperand and failMask. Bit i of failMask stands for policy i.
- R4: On the clock edge that ends an exception cycle, trustedMode becomes 1. tagCheckEn is always the inverse of trustedMode.
- R5: chkFail while trustedMode = 1 is ignored. commitSuppress and redirectValid stay 0, and the saved registers are unchanged.
- R6: chkFail with commitValid = 0 is ignored. There is no suppression, no redirect and no change of state.
- R7: hWrReq loads hWrData into handlerAddr on the next edge only when trustedMode = 1. When trustedMode = 0, handlerAddr is unchanged.
- R8: retReq while trustedMode = 1 gives redirectValid = 1 and redirectPc = retPc in the same cycle, and clears trustedMode on the next edge. retReq while trustedMode = 0 has no effect.
- R9: The saved registers keep their values through every cycle that is not an exception cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chkFail | input | 1 | Tag check failed for the instruction at curPc |
| commitValid | input | 1 | Instruction at curPc is about to commit |
| failMask | input | NPOL | Failing policies, one bit per policy |
| failOperand | input | OPER_W | Identifier of the failing operand |
| curPc | input | PC_W | PC of the checked instruction |
| retReq | input | 1 | Return from handler |
| retPc | input | PC_W | Resume PC for the return |
| hWrReq | input | 1 | Write request for the handler address |
| hWrData | input | PC_W | New handler address |
| commitSuppress | output | 1 | Block commit of the current instruction |
| redirectValid | output | 1 | Fetch redirect this cycle |
| redirectPc | output | PC_W | Redirect target |
| trustedMode | output | 1 | Trusted-mode state |
| tagCheckEn | output | 1 | Tag propagation and checks enabled |
| savedPc | output | PC_W | PC of the last exception |
| savedOperand | output | OPER_W | Failing operand of the last exception |
| savedMask | output | NPOL | Failing policies of the last exception |
| handlerAddr | output | PC_W | Programmed handler address |

## Verification
The block has two kinds of result. commitSuppress, redirectValid and redirectPc are combinational and are due in the same cycle as the stimulus. trustedMode, the saved registers and handlerAddr change on the clock edge that ends the stimulus cycle. The driver applies each stimulus just after a falling edge and queues the expected values: same-cycle values for the redirect outputs, and pre-edge values for the state. The monitor checks them 5 ns later, before the next rising edge. The effect of a stimulus on state therefore shows up in the item queued for the following cycle.

// File: rtl/tagexc_pkg.sv
package tagexc_pkg;
  typedef struct packed {
    logic takeExc;
    logic doRet;
    logic wrHandler;
  } strobe_t;
endpackage

// File: rtl/tagexc_ctrl.sv
module tagexc_ctrl
  import tagexc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    chkFail,
  input  logic    commitValid,
  input  logic    retReq,
  input  logic    hWrReq,
  output strobe_t strobes,
  output logic    trustedMode
);
  logic trustedQ;

  always_comb begin
    strobes.takeExc   = chkFail & commitValid & ~trustedQ;
    strobes.doRet     = retReq & trustedQ;
    strobes.wrHandler = hWrReq & trustedQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  trustedQ <= 1'b1;
    else if (strobes.takeExc)   trustedQ <= 1'b1;
    else if (strobes.doRet)     trustedQ <= 1'b0;
  end

  assign trustedMode = trustedQ;

  // R4
  enter_trusted_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chkFail && commitValid && !trustedMode) |=> trustedMode);
  // R8
  leave_trusted_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retReq && trustedMode) |=> !trustedMode);
  // R5
  stay_trusted_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trustedMode && !retReq) |=> trustedMode);
endmodule

// File: rtl/tagexc_dpath.sv
module tagexc_dpath
  import tagexc_pkg::*;
#(
  parameter int PC_W        = 32,
  parameter int NPOL        = 4,
  parameter int OPER_W      = 2,
  parameter logic [PC_W-1:0] HANDLER_RST = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [NPOL-1:0]   failMask,
  input  logic [OPER_W-1:0] failOperand,
  input  logic [PC_W-1:0]   curPc,
  input  logic [PC_W-1:0]   retPc,
  input  logic [PC_W-1:0]   hWrData,
  output logic [PC_W-1:0]   redirectPc,
  output logic [PC_W-1:0]   savedPc,
  output logic [OPER_W-1:0] savedOperand,
  output logic [NPOL-1:0]   savedMask,
  output logic [PC_W-1:0]   handlerAddr
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      savedPc      <= '0;
      savedOperand <= '0;
      savedMask    <= '0;
    end else if (strobes.takeExc) begin
      savedPc      <= curPc;
      savedOperand <= failOperand;
      savedMask    <= failMask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  handlerAddr <= HANDLER_RST;
    else if (strobes.wrHandler) handlerAddr <= hWrData;
  end

  assign redirectPc = strobes.doRet ? retPc : handlerAddr;

  // R3
  capture_pc_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.takeExc |=> (savedPc == $past(curPc) && savedMask == $past(failMask)));
  // R9
  hold_saved_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.takeExc |=> ($stable(savedPc) && $stable(savedOperand) && $stable(savedMask)));
  // R7
  hold_handler_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrHandler |=> $stable(handlerAddr));
endmodule

// File: rtl/tagexc_unit.sv
module tagexc_unit
  import tagexc_pkg::*;
#(
  parameter int PC_W        = 32,
  parameter int NPOL        = 4,
  parameter int OPER_W      = 2,
  parameter logic [PC_W-1:0] HANDLER_RST = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chkFail,
  input  logic              commitValid,
  input  logic [NPOL-1:0]   failMask,
  input  logic [OPER_W-1:0] failOperand,
  input  logic [PC_W-1:0]   curPc,
  input  logic              retReq,
  input  logic [PC_W-1:0]   retPc,
  input  logic              hWrReq,
  input  logic [PC_W-1:0]   hWrData,
  output logic              commitSuppress,
  output logic              redirectValid,
  output logic [PC_W-1:0]   redirectPc,
  output logic              trustedMode,
  output logic              tagCheckEn,
  output logic [PC_W-1:0]   savedPc,
  output logic [OPER_W-1:0] savedOperand,
  output logic [NPOL-1:0]   savedMask,
  output logic [PC_W-1:0]   handlerAddr
);
  strobe_t strobes;

  tagexc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .chkFail(chkFail), .commitValid(commitValid),
    .retReq(retReq), .hWrReq(hWrReq), .strobes(strobes), .trustedMode(trustedMode)
  );

  tagexc_dpath #(.PC_W(PC_W), .NPOL(NPOL), .OPER_W(OPER_W), .HANDLER_RST(HANDLER_RST)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .failMask(failMask),
    .failOperand(failOperand), .curPc(curPc), .retPc(retPc), .hWrData(hWrData),
    .redirectPc(redirectPc), .savedPc(savedPc), .savedOperand(savedOperand),
    .savedMask(savedMask), .handlerAddr(handlerAddr)
  );

  assign commitSuppress = strobes.takeExc;
  assign redirectValid  = strobes.takeExc | strobes.doRet;
  assign tagCheckEn     = ~trustedMode;

  // R2
  suppress_redirect_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitSuppress |-> (redirectValid && redirectPc == handlerAddr));
  // R5
  no_nested_exc_chk: assert property (@(posedge clk) disable iff (!rstN)
    trustedMode |-> !commitSuppress);
endmodule

// File: tb/sim_tagexc_unit.sv
module sim_tagexc_unit;
  localparam int PC_W = 32, NPOL = 4, OPER_W = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chkFail = 0, commitValid = 0, retReq = 0, hWrReq = 0;
  logic [NPOL-1:0] failMask = '0;
  logic [OPER_W-1:0] failOperand = '0;
  logic [PC_W-1:0] curPc = '0, retPc = '0, hWrData = '0;
  logic commitSuppress, redirectValid, trustedMode, tagCheckEn;
  logic [PC_W-1:0] redirectPc, savedPc, handlerAddr;
  logic [OPER_W-1:0] savedOperand;
  logic [NPOL-1:0] savedMask;

  always #10 clk = ~clk;

  tagexc_unit u0 (.*);

  typedef struct {
    string tag;
    logic sup, rv, tr, te;
    logic [PC_W-1:0] rpc, spc, hadr;
    logic [OPER_W-1:0] sop;
    logic [NPOL-1:0] smask;
  } exp_t;

  exp_t sbq[$];
  int compared = 0, mismatched = 0;
  bit done = 0;

  // reference state derived from the requirements
  logic mTr = 1;
  logic [PC_W-1:0] mSpc = '0, mH = '0;
  logic [OPER_W-1:0] mSop = '0;
  logic [NPOL-1:0] mSm = '0;

  task automatic drive(string tag, logic cf, logic cv, logic [NPOL-1:0] m,
                       logic [OPER_W-1:0] op, logic [PC_W-1:0] pc, logic rt,
                       logic [PC_W-1:0] rpc, logic hw, logic [PC_W-1:0] hd);
    exp_t e;
    logic take, ret;
    @(negedge clk);
    chkFail = cf; commitValid = cv; failMask = m; failOperand = op; curPc = pc;
    retReq = rt; retPc = rpc; hWrReq = hw; hWrData = hd;
    take = cf && cv && !mTr;
    ret  = rt && mTr;
    e.tag = tag; e.sup = take; e.rv = take || ret;
    e.rpc = ret ? rpc : mH;
    if (!e.rv) e.rpc = mH;
    e.tr = mTr; e.te = !mTr; e.spc = mSpc; e.sop = mSop; e.smask = mSm; e.hadr = mH;
    sbq.push_back(e);
    if (take) begin mSpc = pc; mSop = op; mSm = m; mTr = 1; end
    else if (ret) mTr = 0;
    if (hw && mTr && !take) mH = hd;
    if (hw && take) ; // exception cycle is untrusted: write ignored
  endtask

  task automatic idle(string tag);
    drive(tag, 0, 0, '0, '0, '0, 0, '0, 0, '0);
  endtask

  task automatic cmp(string tag, string nm, logic [PC_W-1:0] act, logic [PC_W-1:0] exp, inout bit bad);
    if (act !== exp) begin
      $display("FAIL %s %s actual=%0h expected=%0h", tag, nm, act, exp);
      bad = 1;
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (sbq.size() > 0) begin
        exp_t e;
        bit bad;
        e = sbq.pop_front();
        bad = 0;
        cmp(e.tag, "commitSuppress", PC_W'(commitSuppress), PC_W'(e.sup), bad);
        cmp(e.tag, "redirectValid", PC_W'(redirectValid), PC_W'(e.rv), bad);
        if (e.rv) cmp(e.tag, "redirectPc", redirectPc, e.rpc, bad);
        cmp(e.tag, "trustedMode", PC_W'(trustedMode), PC_W'(e.tr), bad);
        cmp(e.tag, "tagCheckEn", PC_W'(tagCheckEn), PC_W'(e.te), bad);
        cmp(e.tag, "savedPc", savedPc, e.spc, bad);
        cmp(e.tag, "savedOperand", PC_W'(savedOperand), PC_W'(e.sop), bad);
        cmp(e.tag, "savedMask", PC_W'(savedMask), PC_W'(e.smask), bad);
        cmp(e.tag, "handlerAddr", handlerAddr, e.hadr, bad);
        compared++;
        if (bad) mismatched++;
      end
    end
  end

  // watchdog
  initial begin
    #4000000;
    if (!done) begin
      $display("FAIL watchdog actual=running expected=finished");
      mismatched++;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    idle("R1 reset");
    idle("R1 reset");
    rstN = 1'b1;
    idle("R1 after release");
    // program handler while trusted
    drive("R7 write trusted", 0, 0, '0, '0, '0, 0, '0, 1, 32'h400);
    idle("R7 handler visible");
    // leave trusted mode
    drive("R8 return", 0, 0, '0, '0, '0, 1, 32'h100, 0, '0);
    idle("R8 untrusted after return");
    // check fail without commit
    drive("R6 no commit", 1, 0, 4'b0101, 2'd3, 32'h104, 0, '0, 0, '0);
    idle("R6 state unchanged");
    // handler write from untrusted mode
    drive("R7 write untrusted", 0, 0, '0, '0, '0, 0, '0, 1, 32'hBAD);
    idle("R7 handler unchanged");
    // return while untrusted
    drive("R8 return untrusted", 0, 0, '0, '0, '0, 1, 32'h900, 0, '0);
    idle("R8 still untrusted");
    // exception
    drive("R2 exception", 1, 1, 4'b0101, 2'd3, 32'h104, 0, '0, 0, '0);
    idle("R3 R4 saved and trusted");
    // nested fail ignored
    drive("R5 nested fail", 1, 1, 4'b1111, 2'd1, 32'h200, 0, '0, 0, '0);
    idle("R5 R9 saved unchanged");
    drive("R8 return 2", 0, 0, '0, '0, '0, 1, 32'h108, 0, '0);
    idle("R9 hold");
    idle("R9 hold");
    // second exception, different pattern
    drive("R2 exception 2", 1, 1, 4'b1010, 2'd2, 32'h300, 0, '0, 0, '0);
    idle("R3 second capture");
    drive("R7 rewrite trusted", 0, 0, '0, '0, '0, 0, '0, 1, 32'h800);
    drive("R8 return 3", 0, 0, '0, '0, '0, 1, 32'h304, 0, '0);
    drive("R2 exception to new handler", 1, 1, 4'b0001, 2'd0, 32'h308, 0, '0, 0, '0);
    idle("R3 third capture");
    idle("R9 final");
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule